// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block turns parallel words into serial frames on one output line. It sends one bit per clock cycle. There is no bit-rate divider, so the matching receiver must run from the same clock and does no bit-timing recovery. Each frame is a run of low start bits, then the data word with its most significant bit first, then a run of high stop bits. Three parameters set the length of each run, and each must be at least 1.

Words enter through a valid/ready handshake. A word is taken on the rising edge where `s_valid` and `s_ready` are both high, and the block captures it at that edge. `s_ready` is high while the line is idle and during the final stop bit of a frame. In every other cycle `s_ready` is low, and `s_valid` and `s_data` are not sampled at all. If the source keeps `s_valid` high, the next frame begins in the cycle right after the last stop bit, so frames follow each other with no gap. `busy` marks every cycle in which a frame bit is on the line. The synchronous active-low reset aborts any frame and drives the line back to high.

Top module: `sync_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `s_ready` is 1.
- R2: After a word is accepted on an edge, the line carries, from the next cycle on, START_W zeros, then the DATA_W data bits from bit DATA_W-1 down to bit 0, then STOP_W ones, one bit per cycle.
- R3: The data word is the value of `s_data` on the accepting edge. Changes on `s_data` later in the frame do not change the bits that are sent.
- R4: `busy` is 1 in exactly those cycles in which a frame bit (start, data or stop) is driven on `txd`.
- R5: `s_ready` is 1 only while the line is idle or during the final stop bit. An `s_valid` pulse in any other cycle of a frame is ignored and starts no frame.
- R6: While `s_valid` stays high, the first start bit of the next frame follows the final stop bit in the very next cycle, and `busy` stays 1 between the two frames.
- R7: When `rst_n` is low at an edge, the frame in progress is abandoned. From the next cycle, `txd` is 1 and `busy` is 0.
- R8: When no word is accepted during the final stop bit, `txd` is 1 and `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the receiver; one bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | A word is offered on `s_data` |
| s_ready | output | 1 | A word can be taken at this edge |
| s_data | input | DATA_W | Word to be sent |
| busy | output | 1 | A frame bit is on the line |
| txd | output | 1 | Serial line, high when idle |

## Verification
The hardest case is the one-cycle window in which a new request overlaps the final stop bit. Reaching it from the ports needs an `s_valid` that is high exactly on that edge. Long continuous runs hold `s_valid` high while `s_data` changes on every cycle, so the handover happens every frame and the captured word is distinct from its neighbours. Separate phases pulse `s_valid` at every other position inside a frame to show that those pulses are dropped, and a reset is applied in the middle of a data field. A behavioural bit queue predicts the line level, `busy` and `s_ready` on every cycle. A shift-register receiver on `txd` recovers the words and compares them with those accepted.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  // Width of a counter that must hold the values 0 through n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sftx_frame_build.sv
module sftx_frame_build #(
  parameter int unsigned START_W = 1,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned STOP_W  = 1,
  localparam int unsigned TOT_W  = START_W + DATA_W + STOP_W
) (
  input  logic [DATA_W-1:0] word,
  output logic [TOT_W-1:0]  frame
);
  // Bit TOT_W-1 goes out first: the start bits sit at the top, then the word
  // (its MSB first), then the stop bits at the bottom.
  for (genvar i = 0; i < STOP_W; i++) begin : g_stop
    assign frame[i] = 1'b1;
  end
  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign frame[STOP_W + i] = word[i];
  end
  for (genvar i = 0; i < START_W; i++) begin : g_start
    assign frame[STOP_W + DATA_W + i] = 1'b0;
  end
endmodule

// File: rtl/sftx_bit_counter.sv
module sftx_bit_counter #(
  parameter int unsigned TOT_W = 3,
  localparam int unsigned CW   = sftx_pkg::cnt_width(TOT_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic last
);
  logic [CW-1:0] left_q;  // bits still to be sent, counting the current one

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (load)           left_q <= CW'(TOT_W);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
  assign last = (left_q == CW'(1));
endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter #(
  parameter int unsigned TOT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [TOT_W-1:0] frame,
  output logic             line
);
  logic [TOT_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr_q <= '1;
    else if (load)  sr_q <= frame;
    else if (adv)   sr_q <= {sr_q[TOT_W-2:0], 1'b1};  // refill with idle level
  end

  assign line = sr_q[TOT_W-1];
endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx #(
  parameter int unsigned START_W = 2,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned STOP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              busy,
  output logic              txd
);
  localparam int unsigned TOT_W = START_W + DATA_W + STOP_W;

  logic [TOT_W-1:0] frame;
  logic             accept;
  logic             last;

  sftx_frame_build #(.START_W(START_W), .DATA_W(DATA_W), .STOP_W(STOP_W)) u_build (
    .word  (s_data),
    .frame (frame)
  );

  sftx_bit_counter #(.TOT_W(TOT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .busy  (busy),
    .last  (last)
  );

  sftx_shifter #(.TOT_W(TOT_W)) u_sh (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .adv   (busy),
    .frame (frame),
    .line  (txd)
  );

  // Ready while idle or on the final stop bit, so back-to-back frames need no gap.
  assign s_ready = !busy || last;
  assign accept  = s_valid && s_ready;
endmodule

// File: rtl/sync_frame_tx_chk.sv
module sync_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic busy,
  input logic txd
);
  // R1, R8: the line is high whenever no frame bit is being sent
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R5: an idle line always takes a new word
  a_r5_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> s_ready);

  // R2, R6: an accepted word puts a start bit on the line in the next cycle
  a_r2_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (busy && !txd));

  // R5: when not ready in a frame, the frame keeps going
  a_r5_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !s_ready) |=> busy);

  // R7: reset at an edge leaves the line idle in the next cycle
  a_r7_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (txd && !busy));
endmodule

bind sync_frame_tx sync_frame_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .busy    (busy),
  .txd     (txd)
);

// File: tb/sync_frame_tx_tb.sv
module sync_frame_tx_tb;
  localparam int START_W = 2;
  localparam int DATA_W  = 8;
  localparam int STOP_W  = 2;
  localparam int TOT_W   = START_W + DATA_W + STOP_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              s_valid = 1'b0;
  logic [DATA_W-1:0] s_data = '0;
  logic              s_ready, busy, txd;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  sync_frame_tx #(.START_W(START_W), .DATA_W(DATA_W), .STOP_W(STOP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .busy(busy), .txd(txd)
  );

  always #2 clk = ~clk;  // 250 MHz

  // Behavioural model: queue of line bits still to come
  bit              exp_q[$];
  logic [DATA_W-1:0] sent_q[$];

  always @(posedge clk) begin : model
    bit take;
    if (!rst_n) begin
      exp_q.delete();
      sent_q.delete();
    end else begin
      take = s_valid && (exp_q.size() <= 1);
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      if (take) begin
        for (int i = 0; i < START_W; i++) exp_q.push_back(1'b0);
        for (int i = DATA_W - 1; i >= 0; i--) exp_q.push_back(s_data[i]);
        for (int i = 0; i < STOP_W; i++) exp_q.push_back(1'b1);
        sent_q.push_back(s_data);
      end
    end
  end

  // Reference receiver: a frame sits in the window when the oldest bits are
  // zero and the newest bits are one
  logic [TOT_W-1:0] rbuf = '1;
  always @(negedge clk) begin : rx
    logic [TOT_W-1:0] nb;
    if (!rst_n) rbuf <= '1;
    else begin
      nb = {rbuf[TOT_W-2:0], txd};
      if (nb[TOT_W-1 -: START_W] == '0 && (&nb[STOP_W-1:0])) begin
        compared++;
        if (sent_q.size() == 0) begin
          mismatched++;
          $display("FAIL R2 receiver: actual word %0h expected none", nb[STOP_W +: DATA_W]);
        end else begin
          if (nb[STOP_W +: DATA_W] !== sent_q[0]) begin
            mismatched++;
            $display("FAIL R3 receiver: actual %0h expected %0h", nb[STOP_W +: DATA_W], sent_q[0]);
          end
          void'(sent_q.pop_front());
        end
        rbuf <= '1;
      end else rbuf <= nb;
    end
  end

  task automatic compare_now();
    bit et, eb, er;
    et = (exp_q.size() > 0) ? exp_q[0] : 1'b1;
    eb = (exp_q.size() > 0);
    er = (exp_q.size() <= 1);
    compared++;
    if (txd !== et) begin
      mismatched++;
      $display("FAIL R2 txd at %0t: actual %b expected %b", $time, txd, et);
    end
    if (busy !== eb) begin
      mismatched++;
      $display("FAIL R4 busy at %0t: actual %b expected %b", $time, busy, eb);
    end
    if (s_ready !== er) begin
      mismatched++;
      $display("FAIL R5 s_ready at %0t: actual %b expected %b", $time, s_ready, er);
    end
  endtask

  task automatic cyc(input logic v, input logic [DATA_W-1:0] d, input logic r = 1'b1);
    @(negedge clk);
    compare_now();
    s_valid = v;
    s_data  = d;
    rst_n   = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, DATA_W'($urandom));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b1);
    compared++;
    if (txd !== 1'b1 || busy !== 1'b0 || s_ready !== 1'b1) begin
      mismatched++;
      $display("FAIL R1 reset: actual txd=%b busy=%b rdy=%b expected 1 0 1", txd, busy, s_ready);
    end

    // R2, R3, R8: single frame, data toggled and pulses during the frame (R5)
    cyc(1'b1, 8'hA5);
    for (int i = 0; i < TOT_W + 4; i++) cyc((i % 3) == 1 && i < TOT_W - 2, DATA_W'($urandom));
    idle(3);
    cyc(1'b1, 8'h01);
    idle(TOT_W + 3);

    // R5: one pulse at each mid-frame position, then let it drain
    for (int p = 1; p < TOT_W - 1; p++) begin
      cyc(1'b1, DATA_W'(8'h80 | p));
      for (int i = 1; i < TOT_W + 3; i++) cyc(i == p, DATA_W'($urandom));
    end

    // R6: continuous mode, data changing every cycle
    for (int i = 0; i < 8 * TOT_W; i++) cyc(1'b1, DATA_W'($urandom));
    idle(TOT_W + 2);

    // R6: request raised exactly on the final stop bit
    cyc(1'b1, 8'h3C);
    for (int i = 1; i < TOT_W; i++) cyc(1'b0, 8'hFF);
    cyc(1'b1, 8'hC3);
    idle(TOT_W + 2);

    // R7: reset in the middle of the data field
    cyc(1'b1, 8'h00);
    idle(START_W + 3);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b1);
    idle(TOT_W + 2);

    // Random traffic covering all requirements
    for (int i = 0; i < 2000; i++) cyc(($urandom % 4) != 0, DATA_W'($urandom));
    idle(TOT_W + 2);

    // R2: every accepted word was recovered
    compared++;
    if (sent_q.size() != 0) begin
      mismatched++;
      $display("FAIL R2 words left: actual %0d expected 0", sent_q.size());
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule